// File: doc/BRIEF.md
# Line Refill Controller with Early Processor Release

This controller fills one cache line of `WORDS` words from lower memory after a read miss. It lets the processor go again as soon as the word it missed on has come back, and does not wait for the whole line. Lower memory gets one word address per request handshake and sends the words back in the order they were asked for. Each returned word goes straight to the cache array at its own slot in the line. The same word goes to the processor in the cycle it arrives if it is the missed word.

A static mode input picks the order in which the words are fetched. In wrap mode the missed word is asked for first, and the others follow in rising order, wrapping past the end of the line back to slot 0. In ascending mode the fetch always starts at slot 0 and climbs, and the missed word is passed on whenever its turn comes. Until the whole line has been written, the controller refuses any further miss.

Top module: `line_refill_ctrl`

## Requirements
- R1: Once reset has been released and two clock edges have passed, `miss_ready` is 1 and `mem_req_valid`, `arr_wr_en`, `cpu_data_valid` and `arr_line_valid` are all 0.
- R2: With `order_mode` = 1, the k-th request of a refill (k counted from 0) carries the word address `{line, (crit + k) mod WORDS}`. Here `line` is `miss_addr` with its low log2(WORDS) bits removed, and `crit` is those low bits.
- R3: With `order_mode` = 0, the k-th request of a refill carries `{line, k}`, so slot 0 is asked for first.
- R4: A response accepted during a refill drives `arr_wr_en` = 1 in the same cycle. `arr_wr_idx` is the slot that the matching request named, `arr_wr_data` equals `mem_rsp_data`, and `arr_line_addr` is `{line, 0}`.
- R5: `cpu_data_valid` is 1 in exactly one cycle per refill. That cycle is the one in which the response for slot `crit` arrives, and `cpu_data` equals that word.
- R6: `arr_line_valid` is 1 in exactly one cycle per refill, the cycle of the final response. It is 0 for all earlier responses.
- R7: `miss_ready` is 0 from the edge that accepts a miss until the edge that takes the final response. A miss presented in between does not change the line being fetched.
- R8: Each refill issues exactly `WORDS` requests. A request that is not accepted keeps `mem_req_valid` high and its address unchanged until `mem_req_ready` is 1. No request is issued after the last one has been accepted.
- R9: A response that arrives while no refill is in progress is ignored: `arr_wr_en`, `cpu_data_valid` and `arr_line_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_mode | input | 1 | 1 = missed word first with wrap, 0 = ascending from slot 0 |
| miss_valid | input | 1 | Read miss presented |
| miss_addr | input | ADDR_W | Word address of the missed word |
| miss_ready | output | 1 | Controller idle, miss accepted when valid |
| mem_req_valid | output | 1 | Word request to lower memory |
| mem_req_addr | output | ADDR_W | Word address requested |
| mem_req_ready | input | 1 | Lower memory takes the request |
| mem_rsp_valid | input | 1 | Returned word present |
| mem_rsp_data | input | DATA_W | Returned word |
| arr_wr_en | output | 1 | Write one word into the cache line |
| arr_wr_idx | output | log2(WORDS) | Slot written |
| arr_wr_data | output | DATA_W | Word written |
| arr_line_addr | output | ADDR_W | Word address of slot 0 of the line |
| arr_line_valid | output | 1 | Line complete, mark it valid |
| cpu_data_valid | output | 1 | Missed word delivered to the processor |
| cpu_data | output | DATA_W | Missed word |

## Verification
Two events can fall in the same cycle: the missed word being passed to the processor, and the line being declared complete. This happens when the missed slot is the last one fetched, which in ascending mode means slot `WORDS-1`. The bench sweeps every missed slot in both modes, so that case is always reached. On that response it requires `cpu_data_valid` and `arr_line_valid` to be high together, with the forward still counted exactly once. A second overlap is a new miss arriving while a refill is running. The bench presents one in the middle of a refill and judges it by the request addresses, which must keep to the original line, and by `miss_ready` staying low until the line is done.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;

  localparam logic ORDER_ASCEND = 1'b0;
  localparam logic ORDER_WRAP   = 1'b1;
endpackage

// File: rtl/refill_offset_map.sv
// Maps a step count within the refill to a word slot, rotating by a base slot.
module refill_offset_map #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic [OFF_W-1:0] base,
  input  logic [OFF_W-1:0] step,
  output logic [OFF_W-1:0] slot
);
  generate
    if ((1 << OFF_W) == WORDS) begin : g_pow2
      // Natural wrap of the adder gives modulo WORDS.
      assign slot = base + step;
    end else begin : g_generic
      localparam logic [OFF_W:0] WORDS_V = (OFF_W+1)'(WORDS);
      logic [OFF_W:0] sum;
      logic [OFF_W:0] folded;
      always_comb begin
        sum    = {1'b0, base} + {1'b0, step};
        folded = (sum >= WORDS_V) ? (sum - WORDS_V) : sum;
      end
      assign slot = folded[OFF_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/refill_req_seq.sv
// Issues WORDS request steps, one per accepted handshake.
module refill_req_seq #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [OFF_W-1:0] req_step
);
  localparam logic [OFF_W:0] LAST = (OFF_W+1)'(WORDS - 1);

  logic             active_q, active_d;
  logic [OFF_W:0]   cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    upd      = 1'b0;
    if (launch) begin
      upd      = 1'b1;
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && req_ready) begin
      upd   = 1'b1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (upd) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign req_valid = active_q;
  assign req_step  = cnt_q[OFF_W-1:0];

  // R8: a stalled request holds its step.
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !launch) |=> (req_valid && $stable(req_step)));
endmodule

// File: rtl/refill_rsp_seq.sv
// Counts returned words of the refill and flags the final one.
module refill_rsp_seq #(
  parameter int WORDS = 8,
  parameter int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             busy,
  input  logic             rsp_valid,
  output logic             rsp_take,
  output logic             rsp_last,
  output logic [OFF_W-1:0] rsp_step
);
  localparam logic [OFF_W:0] LAST = (OFF_W+1)'(WORDS - 1);

  logic [OFF_W:0] cnt_q, cnt_d;
  logic           upd;

  always_comb begin
    rsp_take = busy && rsp_valid;
    rsp_last = rsp_take && (cnt_q == LAST);
    upd      = launch || rsp_take;
    cnt_d    = launch ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign rsp_step = cnt_q[OFF_W-1:0];

  // R6: no response is taken past the last slot of the line.
  p_rsp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |-> (cnt_q <= LAST));
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
  import refill_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_mode,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              miss_ready,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              arr_wr_en,
  output logic [OFF_W-1:0]  arr_wr_idx,
  output logic [DATA_W-1:0] arr_wr_data,
  output logic [ADDR_W-1:0] arr_line_addr,
  output logic              arr_line_valid,
  output logic              cpu_data_valid,
  output logic [DATA_W-1:0] cpu_data
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fill_state_e       state_q, state_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [OFF_W-1:0]  crit_q, crit_d;
  logic [OFF_W-1:0]  start_q, start_d;
  logic              accept, cap_en;

  logic              req_valid_w;
  logic [OFF_W-1:0]  req_step_w, req_slot_w;
  logic              rsp_take_w, rsp_last_w;
  logic [OFF_W-1:0]  rsp_step_w, rsp_slot_w;

  always_comb begin
    miss_ready = (state_q == FILL_IDLE);
    accept     = miss_valid && miss_ready;
    cap_en     = accept;
    line_d     = miss_addr[ADDR_W-1:OFF_W];
    crit_d     = miss_addr[OFF_W-1:0];
    start_d    = (order_mode == ORDER_WRAP) ? miss_addr[OFF_W-1:0] : '0;
    state_d    = state_q;
    unique case (state_q)
      FILL_IDLE: if (accept)     state_d = FILL_BUSY;
      FILL_BUSY: if (rsp_last_w) state_d = FILL_IDLE;
      default:                   state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= FILL_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      line_q  <= '0;
      crit_q  <= '0;
      start_q <= '0;
    end else if (cap_en) begin
      line_q  <= line_d;
      crit_q  <= crit_d;
      start_q <= start_d;
    end
  end

  refill_req_seq #(.WORDS(WORDS), .OFF_W(OFF_W)) req_seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (accept),
    .req_ready (mem_req_ready),
    .req_valid (req_valid_w),
    .req_step  (req_step_w)
  );

  refill_rsp_seq #(.WORDS(WORDS), .OFF_W(OFF_W)) rsp_seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .launch    (accept),
    .busy      (state_q == FILL_BUSY),
    .rsp_valid (mem_rsp_valid),
    .rsp_take  (rsp_take_w),
    .rsp_last  (rsp_last_w),
    .rsp_step  (rsp_step_w)
  );

  refill_offset_map #(.WORDS(WORDS), .OFF_W(OFF_W)) req_map_i (
    .base (start_q),
    .step (req_step_w),
    .slot (req_slot_w)
  );

  refill_offset_map #(.WORDS(WORDS), .OFF_W(OFF_W)) rsp_map_i (
    .base (start_q),
    .step (rsp_step_w),
    .slot (rsp_slot_w)
  );

  always_comb begin
    mem_req_valid  = req_valid_w;
    mem_req_addr   = {line_q, req_slot_w};
    arr_wr_en      = rsp_take_w;
    arr_wr_idx     = rsp_slot_w;
    arr_wr_data    = mem_rsp_data;
    arr_line_addr  = {line_q, {OFF_W{1'b0}}};
    arr_line_valid = rsp_last_w;
    cpu_data_valid = rsp_take_w && (rsp_slot_w == crit_q);
    cpu_data       = mem_rsp_data;
  end

  // Checker state: has the missed word been delivered in this refill.
  logic fwd_seen_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)         fwd_seen_q <= 1'b0;
    else if (accept)         fwd_seen_q <= 1'b0;
    else if (cpu_data_valid) fwd_seen_q <= 1'b1;
  end

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    miss_ready |-> (!arr_wr_en && !cpu_data_valid && !arr_line_valid));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_line_valid |=> miss_ready);

  p_first_req_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> (mem_req_valid && !miss_ready));

  p_fwd_once_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_data_valid |-> !fwd_seen_q);

  p_fwd_before_done_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    arr_line_valid |-> (fwd_seen_q || cpu_data_valid));
endmodule

// File: tb/line_refill_ctrl_tb.sv
`timescale 1ns/1ps
module line_refill_ctrl_tb_top;
  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;
  localparam int WORDS  = 8;
  localparam int OFF_W  = 3;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              order_mode;
  logic              miss_valid;
  logic [ADDR_W-1:0] miss_addr;
  logic              miss_ready;
  logic              mem_req_valid;
  logic [ADDR_W-1:0] mem_req_addr;
  logic              mem_req_ready;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;
  logic              arr_wr_en;
  logic [OFF_W-1:0]  arr_wr_idx;
  logic [DATA_W-1:0] arr_wr_data;
  logic [ADDR_W-1:0] arr_line_addr;
  logic              arr_line_valid;
  logic              cpu_data_valid;
  logic [DATA_W-1:0] cpu_data;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  line_refill_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .order_mode(order_mode),
    .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .arr_wr_en(arr_wr_en), .arr_wr_idx(arr_wr_idx),
    .arr_wr_data(arr_wr_data), .arr_line_addr(arr_line_addr),
    .arr_line_valid(arr_line_valid), .cpu_data_valid(cpu_data_valid),
    .cpu_data(cpu_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] ln,
                                                input logic [OFF_W-1:0] s);
    return 32'hA500_0000 ^ {ln[19:0], 9'h0, s};
  endfunction

  // R1: state after reset release.
  task automatic t_reset();
    rst_n = 1'b0;
    order_mode = 1'b0; miss_valid = 1'b0; miss_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(miss_ready == 1'b1, "R1", "miss_ready", 64'(miss_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    check(arr_wr_en == 1'b0, "R1", "arr_wr_en", 64'(arr_wr_en), 64'd0);
    check(cpu_data_valid == 1'b0, "R1", "cpu_data_valid", 64'(cpu_data_valid), 64'd0);
    check(arr_line_valid == 1'b0, "R1", "arr_line_valid", 64'(arr_line_valid), 64'd0);
  endtask

  // R9: a stray response while idle writes nothing.
  task automatic t_idle_rsp();
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hDEAD_BEEF;
    #1;
    check(arr_wr_en == 1'b0, "R9", "arr_wr_en", 64'(arr_wr_en), 64'd0);
    check(cpu_data_valid == 1'b0, "R9", "cpu_data_valid", 64'(cpu_data_valid), 64'd0);
    check(arr_line_valid == 1'b0, "R9", "arr_line_valid", 64'(arr_line_valid), 64'd0);
    @(posedge clk);
    @(negedge clk) mem_rsp_valid = 1'b0;
    #1;
    check(miss_ready == 1'b1, "R9", "miss_ready after stray", 64'(miss_ready), 64'd1);
  endtask

  // One full refill; covers R2..R8 depending on mode and options.
  task automatic t_refill(input logic mode, input logic [OFF_W-1:0] crit,
                          input logic [LINE_W-1:0] ln, input bit stall, input bit inject);
    int fwd_cnt = 0;
    logic [OFF_W-1:0] exp_slot;
    @(negedge clk);
    order_mode = mode;
    miss_valid = 1'b1; miss_addr = {ln, crit};
    #1;
    check(miss_ready == 1'b1, "R7", "ready before miss", 64'(miss_ready), 64'd1);
    @(posedge clk);
    @(negedge clk) miss_valid = 1'b0;
    for (int k = 0; k < WORDS; k++) begin
      exp_slot = mode ? OFF_W'(crit + OFF_W'(k)) : OFF_W'(k);
      if (inject && k == 3) begin miss_valid = 1'b1; miss_addr = {ln + 27'd1, 3'd0}; end
      if (inject && k == 5) miss_valid = 1'b0;
      if (stall && k[0]) begin
        mem_req_ready = 1'b0;
        #1;
        check(mem_req_valid == 1'b1, "R8", "valid held", 64'(mem_req_valid), 64'd1);
        @(posedge clk);
        @(negedge clk);
        check(mem_req_valid == 1'b1 && mem_req_addr == {ln, exp_slot}, "R8",
              "stalled addr", 64'(mem_req_addr), 64'({ln, exp_slot}));
      end
      mem_req_ready = 1'b1;
      #1;
      check(miss_ready == 1'b0, "R7", "ready during refill", 64'(miss_ready), 64'd0);
      check(mem_req_valid == 1'b1 && mem_req_addr == {ln, exp_slot}, mode ? "R2" : "R3",
            "request addr", 64'(mem_req_addr), 64'({ln, exp_slot}));
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = word_of(ln, exp_slot);
      #1;
      check(arr_wr_en == 1'b1 && arr_wr_idx == exp_slot &&
            arr_wr_data == word_of(ln, exp_slot) && arr_line_addr == {ln, 3'd0},
            "R4", "array write idx", 64'(arr_wr_idx), 64'(exp_slot));
      check(cpu_data_valid == (exp_slot == crit), "R5", "forward strobe",
            64'(cpu_data_valid), 64'(exp_slot == crit));
      if (cpu_data_valid) begin
        fwd_cnt++;
        check(cpu_data == word_of(ln, crit), "R5", "forward data",
              64'(cpu_data), 64'(word_of(ln, crit)));
      end
      check(arr_line_valid == (k == WORDS - 1), "R6", "line valid",
            64'(arr_line_valid), 64'(k == WORDS - 1));
      if (k == WORDS - 1)
        check(mem_req_valid == 1'b0, "R8", "no extra request", 64'(mem_req_valid), 64'd0);
      @(posedge clk);
      @(negedge clk) mem_rsp_valid = 1'b0;
    end
    check(fwd_cnt == 1, "R5", "forward count", 64'(fwd_cnt), 64'd1);
    #1;
    check(miss_ready == 1'b1, "R7", "ready after line", 64'(miss_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R8", "idle after line", 64'(mem_req_valid), 64'd0);
  endtask

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_rsp();
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < WORDS; c++) begin
        t_refill(m[0], OFF_W'(c), LINE_W'(27'h123 + c + 16 * m), c[0], c == 5);
      end
    end
    t_idle_rsp();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule